// File: doc/BRIEF.md
# Rate-Sensor SPI Register Target

This block is an SPI slave that presents the register interface of a three-axis angular-rate sensor. It can stand in as a test target for a host driver or sit in front of real sensing logic. The host sends one command byte per transaction. That byte chooses read or write, turns address auto-increment on or off, and gives a 6-bit register address. After the command byte, the block either takes one data byte into a writable register or returns register contents on MISO for as long as the host keeps clocking.

The SPI pins are oversampled in the system clock domain. Each pin passes through a synchronizer, and edges on SCK are found after synchronization. A parallel port on the system side loads a fresh X/Y/Z sample set and a temperature byte in a single cycle. Each load updates per-axis data-ready and overrun flags. Reading an axis's output bytes over SPI clears that axis's flags.

Top module: `gyro_spi_slave`

## Requirements
- R1: The first byte after chip select falls is the command byte, sent most significant bit first. Bit 7 set means read and bit 7 clear means write. Bit 6 set turns on auto-increment. Bits 5:0 hold the register address.
- R2: A write stores only the byte that follows the command, and only when the address lies in 0x20..0x25. Bytes after the second are ignored, and writes to any other address change nothing.
- R3: A read of address 0x0F always returns 0xD4, whether or not that address has been written.
- R4: Addresses 0x20..0x24 are read/write control bytes and 0x25 is a read/write reference byte. 0x26 returns the temperature and 0x27 returns the status byte. 0x28..0x2D return X low, X high, Y low, Y high, Z low, Z high. Every other address reads 0. After reset, every register reads 0 except 0x0F.
- R5: The status byte holds per-axis new-data flags in bits 0 (X), 1 (Y) and 2 (Z). Bit 3 is the AND of those three. Bits 4, 5 and 6 hold the X, Y and Z overrun flags, and bit 7 is the AND of the three overrun flags.
- R6: A one-cycle pulse on `smp_load` captures all samples and sets all three new-data flags. An axis whose new-data flag was already set before the pulse also gets its overrun flag set.
- R7: Once an axis's high output byte (0x29, 0x2B or 0x2D) has been fully shifted out, that axis's new-data and overrun flags clear. A byte that the block prefetched but the host did not clock out clears nothing.
- R8: With auto-increment on, each further read byte comes from the next address, and the address wraps from 0x3F to 0x00. With auto-increment off, every read byte comes from the same address.
- R9: SPI mode 3 is used. MOSI is sampled on rising SCK, MISO changes only after a falling SCK edge, and MISO is 0 while chip select is high.
- R10: Raising chip select in the middle of a byte throws the partial byte away, and the next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 while deselected |
| smp_load | input | 1 | Capture strobe for a new sample set |
| smp_x | input | 16 | X rate sample, two's complement |
| smp_y | input | 16 | Y rate sample, two's complement |
| smp_z | input | 16 | Z rate sample, two's complement |
| smp_temp | input | 8 | Temperature byte |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 and drives SCK with a half period of eight system clocks. This leaves the MISO path (three synchronizer stages, one edge-detect stage and one output register) only a few cycles of margin before the host samples. A timing error in the pipeline therefore shows up as a shifted bit. The directed cases reach the 64-address wrap, the prefetch that must not clear flags, a write with trailing bytes, and an aborted half byte. Random reads, writes and sample loads then mix flag setting and clearing in orders the directed cases do not cover.

// File: rtl/gyro_pkg.sv
package gyro_pkg;
  localparam int AW      = 6;
  localparam int AXES    = 3;
  localparam int SMP_W   = 16;
  localparam int CFG_N   = 6;
  localparam int CFG_IW  = $clog2(CFG_N);

  localparam logic [AW-1:0] A_ID    = 6'h0F;
  localparam logic [AW-1:0] A_CFG0  = 6'h20;
  localparam logic [AW-1:0] A_CFGL  = A_CFG0 + AW'(CFG_N - 1);
  localparam logic [AW-1:0] A_TEMP  = 6'h26;
  localparam logic [AW-1:0] A_STAT  = 6'h27;
  localparam logic [AW-1:0] A_OUT0  = 6'h28;
  localparam logic [AW-1:0] A_OUTL  = A_OUT0 + AW'(2 * AXES - 1);
  localparam logic [7:0]    ID_VAL  = 8'hD4;

  // One-hot axis selected when the high byte of that axis is read
  function automatic logic [AXES-1:0] axis_of_hi(input logic [AW-1:0] a);
    logic [AXES-1:0] r;
    r = '0;
    for (int i = 0; i < AXES; i++)
      if (a == A_OUT0 + AW'(2 * i + 1)) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic active,
  output logic rise,
  output logic fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_p, cs_p, mo_p;
  logic sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '1;
      cs_p  <= '1;
      mo_p  <= '0;
      sck_d <= 1'b1;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sck};
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      mo_p  <= {mo_p[STAGES-2:0], mosi};
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign active = ~cs_p[STAGES-1];
  assign rise   = active &  sck_p[STAGES-1] & ~sck_d;
  assign fall   = active & ~sck_p[STAGES-1] &  sck_d;
  assign mosi_s = mo_p[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       rise,
  input  logic       din,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [1:0] byte_idx
);
  logic [2:0] bit_q;
  logic [6:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
      byte_idx  <= '0;
      if (rst) byte_val <= '0;
    end else begin
      byte_done <= 1'b0;
      if (byte_done && byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
      if (rise) begin
        sh_q  <= {sh_q[5:0], din};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          byte_val  <= {sh_q, din};
          byte_done <= 1'b1;
        end
      end
    end
  end

  // R10: deselect discards any partial byte
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_q == 3'd0 && !byte_done && byte_idx == 2'd0));
endmodule

// File: rtl/gyro_regs.sv
module gyro_regs
  import gyro_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_load,
  input  logic [AXES-1:0][SMP_W-1:0] smp_in,
  input  logic [7:0]                 smp_temp,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic [AW-1:0]              rd_addr,
  input  logic [AXES-1:0]            clr_axis,
  output logic [7:0]                 rd_data
);
  logic [7:0]       cfg_q [CFG_N];
  logic [SMP_W-1:0] smp_q [AXES];
  logic [7:0]       temp_q;
  logic [AXES-1:0]  rdy_q, ovr_q;
  logic [7:0]       status;
  logic [AW-1:0]    woff, roff, ooff;

  assign woff = wr_addr - A_CFG0;
  assign roff = rd_addr - A_CFG0;
  assign ooff = rd_addr - A_OUT0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_N; i++) cfg_q[i] <= '0;
    end else if (wr_en && wr_addr >= A_CFG0 && wr_addr <= A_CFGL) begin
      cfg_q[woff[CFG_IW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
      for (int i = 0; i < AXES; i++) smp_q[i] <= '0;
    end else if (smp_load) begin
      temp_q <= smp_temp;
      for (int i = 0; i < AXES; i++) smp_q[i] <= smp_in[i];
    end
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (rst) begin
        rdy_q[a] <= 1'b0;
        ovr_q[a] <= 1'b0;
      end else if (smp_load) begin
        ovr_q[a] <= ovr_q[a] | rdy_q[a];
        rdy_q[a] <= 1'b1;
      end else if (clr_axis[a]) begin
        rdy_q[a] <= 1'b0;
        ovr_q[a] <= 1'b0;
      end
    end

    // R6: load with pending data flags overrun
    a_r6_overrun: assert property (@(posedge clk) disable iff (rst)
      (smp_load && rdy_q[a]) |=> ovr_q[a]);
    // R7: a completed high-byte read clears the axis
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_axis[a] && !smp_load) |=> (!rdy_q[a] && !ovr_q[a]));
  end

  assign status = {&ovr_q, ovr_q, &rdy_q, rdy_q};

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_ID)                               rd_data = ID_VAL;
    else if (rd_addr >= A_CFG0 && rd_addr <= A_CFGL)   rd_data = cfg_q[roff[CFG_IW-1:0]];
    else if (rd_addr == A_TEMP)                        rd_data = temp_q;
    else if (rd_addr == A_STAT)                        rd_data = status;
    else if (rd_addr >= A_OUT0 && rd_addr <= A_OUTL)
      rd_data = ooff[0] ? smp_q[ooff[2:1]][15:8] : smp_q[ooff[2:1]][7:0];
  end

  // R6: every load leaves all data-ready flags set
  a_r6_ready: assert property (@(posedge clk) disable iff (rst)
    smp_load |=> (rdy_q == '1));
endmodule

// File: rtl/gyro_spi_slave.sv
module gyro_spi_slave
  import gyro_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             smp_load,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  input  logic [7:0]       smp_temp
);
  logic active, sck_rise, sck_fall, mosi_s;
  logic byte_done;
  logic [7:0] byte_val, rd_data, tx_q;
  logic [1:0] byte_idx;
  logic rd_q, inc_q, miso_q;
  logic [AW-1:0] ptr_q, rd_addr;
  logic [AXES-1:0] clr_pend_q, clr_axis;
  logic is_cmd, rd_step, wr_en;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .active(active), .rise(sck_rise), .fall(sck_fall), .mosi_s(mosi_s));

  spi_byte_rx u_rx (
    .clk(clk), .rst(rst), .active(active), .rise(sck_rise), .din(mosi_s),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx));

  assign is_cmd   = byte_done && byte_idx == 2'd0;
  assign rd_step  = byte_done && byte_idx != 2'd0 && rd_q;
  assign wr_en    = byte_done && byte_idx == 2'd1 && !rd_q;
  assign rd_addr  = (byte_idx == 2'd0) ? byte_val[AW-1:0] : ptr_q;
  assign clr_axis = rd_step ? clr_pend_q : '0;

  gyro_regs u_regs (
    .clk(clk), .rst(rst), .smp_load(smp_load),
    .smp_in({smp_z, smp_y, smp_x}), .smp_temp(smp_temp),
    .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(byte_val),
    .rd_addr(rd_addr), .clr_axis(clr_axis), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      inc_q <= 1'b0;
      ptr_q <= '0;
    end else if (is_cmd) begin
      rd_q  <= byte_val[7];
      inc_q <= byte_val[6];
      ptr_q <= byte_val[AW-1:0] + AW'(byte_val[7] & byte_val[6]);
    end else if (rd_step) begin
      ptr_q <= ptr_q + AW'(inc_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      tx_q       <= '0;
      miso_q     <= 1'b0;
      clr_pend_q <= '0;
    end else if (is_cmd && byte_val[7]) begin
      tx_q       <= rd_data;
      clr_pend_q <= axis_of_hi(byte_val[AW-1:0]);
    end else if (rd_step) begin
      tx_q       <= rd_data;
      clr_pend_q <= axis_of_hi(ptr_q);
    end else if (sck_fall) begin
      miso_q <= tx_q[7];
      tx_q   <= {tx_q[6:0], 1'b0};
    end
  end

  assign spi_miso = miso_q;

  // R9: MISO quiet while deselected
  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |=> !spi_miso);
  // R9: MISO moves only after a falling SCK edge
  a_r9_fall_only: assert property (@(posedge clk) disable iff (rst)
    (active && !sck_fall) |=> $stable(spi_miso));
  // R3: identity address loads the fixed code
  a_r3_id_code: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && byte_val[7] && byte_val[AW-1:0] == A_ID) |=> tx_q == ID_VAL);
  // R8: without auto-increment the pointer holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_step && !inc_q) |=> ptr_q == $past(ptr_q));
endmodule

// File: tb/sim_gyro_spi_slave.sv
`timescale 1ns/1ps
module sim_gyro_spi_slave;
  localparam int HP = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0, smp_load = 1'b0;
  logic miso;
  logic [15:0] sx = '0, sy = '0, sz = '0;
  logic [7:0] st = '0;
  int checks = 0, errors = 0;
  logic [7:0] tx_b [0:39];
  logic [7:0] rx_b [0:39];
  logic [7:0] cfg_m [0:5];
  logic [15:0] xyz_m [0:2];
  logic [7:0] temp_m;
  logic [2:0] rdy_m, ovr_m;

  always #2.5 clk = ~clk;

  gyro_spi_slave #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .smp_load(smp_load), .smp_x(sx), .smp_y(sy), .smp_z(sz),
    .smp_temp(st));

  function automatic logic [7:0] stat_m();
    return {&ovr_m, ovr_m, &rdy_m, rdy_m};
  endfunction

  function automatic logic [7:0] mread(input logic [5:0] a);
    if (a == 6'h0F) return 8'hD4;
    if (a >= 6'h20 && a <= 6'h25) return cfg_m[a - 6'h20];
    if (a == 6'h26) return temp_m;
    if (a == 6'h27) return stat_m();
    if (a >= 6'h28 && a <= 6'h2D)
      return (a[0]) ? xyz_m[(a - 6'h28) >> 1][15:8] : xyz_m[(a - 6'h28) >> 1][7:0];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(posedge clk);
    #1;
  endtask

  task automatic spi_run(input int n);
    cs_n = 1'b0;
    wait_hp();
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        sck = 1'b0; mosi = tx_b[k][b];
        wait_hp();
        rx_b[k][b] = miso;
        sck = 1'b1;
        wait_hp();
      end
    cs_n = 1'b1;
    repeat (3) wait_hp();
  endtask

  // R1/R4/R7/R8: read n bytes and compare each against the model
  task automatic do_read(input logic [5:0] a, input logic inc, input int n, input string req);
    logic [5:0] p;
    tx_b[0] = {1'b1, inc, a};
    for (int k = 1; k <= n; k++) tx_b[k] = 8'($urandom);
    spi_run(n + 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      chk(req, rx_b[k + 1], mread(p));
      if (p == 6'h29) begin rdy_m[0] = 1'b0; ovr_m[0] = 1'b0; end
      if (p == 6'h2B) begin rdy_m[1] = 1'b0; ovr_m[1] = 1'b0; end
      if (p == 6'h2D) begin rdy_m[2] = 1'b0; ovr_m[2] = 1'b0; end
      if (inc) p = p + 6'd1;
    end
  endtask

  // R2: command, one data byte, optional trailing bytes
  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input int extra);
    tx_b[0] = {2'b00, a};
    tx_b[1] = d;
    for (int k = 2; k < 2 + extra; k++) tx_b[k] = 8'($urandom);
    spi_run(2 + extra);
    if (a >= 6'h20 && a <= 6'h25) cfg_m[a - 6'h20] = d;
  endtask

  task automatic do_load(input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] z, input logic [7:0] t);
    @(posedge clk); #1;
    sx = x; sy = y; sz = z; st = t; smp_load = 1'b1;
    @(posedge clk); #1;
    smp_load = 1'b0;
    xyz_m[0] = x; xyz_m[1] = y; xyz_m[2] = z; temp_m = t;
    ovr_m = ovr_m | rdy_m;
    rdy_m = 3'b111;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) cfg_m[i] = '0;
    for (int i = 0; i < 3; i++) xyz_m[i] = '0;
    temp_m = '0; rdy_m = '0; ovr_m = '0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 idle miso", {7'd0, miso}, 8'h00);
    do_read(6'h0F, 1'b0, 1, "R3 id");
    do_read(6'h20, 1'b1, 8, "R4 reset values");

    do_write(6'h20, 8'hA5, 0);
    do_write(6'h25, 8'h3C, 0);
    do_write(6'h0F, 8'h00, 0);
    do_write(6'h27, 8'hFF, 0);
    do_write(6'h21, 8'h11, 2);
    do_read(6'h20, 1'b1, 6, "R2 write and trailing bytes");
    do_read(6'h0F, 1'b0, 1, "R3 id after write");
    do_read(6'h27, 1'b0, 1, "R2 status unwritable");

    do_load(16'h1234, 16'hBEEF, 16'h8001, 8'h19);
    do_read(6'h27, 1'b0, 2, "R5 R6 ready flags");
    do_load(16'h7FFF, 16'h0102, 16'hFFFE, 8'hE7);
    do_read(6'h27, 1'b0, 1, "R6 overrun flags");
    do_read(6'h26, 1'b1, 8, "R4 R7 burst from temperature");
    do_read(6'h27, 1'b0, 1, "R7 flags cleared");

    do_load(16'h5A5A, 16'h0F0F, 16'hC3C3, 8'h22);
    do_read(6'h29, 1'b0, 3, "R8 repeat without increment");
    do_read(6'h27, 1'b0, 1, "R7 only X cleared");
    do_read(6'h2A, 1'b1, 1, "R7 prefetch no clear");
    do_read(6'h27, 1'b0, 1, "R7 prefetched high byte untouched");
    do_read(6'h2D, 1'b1, 35, "R8 wrap within six bits");

    // R10: partial byte then deselect
    cs_n = 1'b0; wait_hp();
    for (int b = 0; b < 4; b++) begin
      sck = 1'b0; mosi = 1'b1; wait_hp(); sck = 1'b1; wait_hp();
    end
    cs_n = 1'b1; repeat (3) wait_hp();
    do_write(6'h22, 8'h77, 0);
    do_read(6'h22, 1'b0, 1, "R10 abort then write");

    for (int it = 0; it < 120; it++) begin
      case ($urandom % 4)
        0: do_write(6'($urandom), 8'($urandom), int'($urandom % 2));
        1: do_read(6'($urandom), 1'($urandom), 1 + int'($urandom % 4), "R1 random read");
        2: do_load(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
        default: do_read(6'h26, 1'b1, 8, "R5 R7 random burst");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule